// File: doc/BRIEF.md
# Packetized Host Write Decoder

This block sits behind a 16-bit host link and turns a stream of half-words into 32-bit writes for a register file or a small memory. The host opens every packet with a one-word header that names a 7-bit start address and a count of 32-bit words. The header is repeated in the very next accepted beat. Only a pair of identical, legal copies opens the packet. The payload words follow, each split into two 16-bit beats, low half first. The decoder joins the halves and issues one write per word on a single-cycle write strobe.

Addresses step up by one per word. The exception is a start address of 126, which acts as a fixed sink: every word of such a packet lands at 126, as a FIFO port would need. Address 127 never receives a write. A header that names it is rejected, and an incrementing packet that runs past 126 wraps to 0. A rejected header pair raises a one-cycle error pulse, and both copies are dropped. The stream is qualified by a valid bit, so the host may stall between any two beats.

Top module: `pwd_write_decoder`

## Requirements
- R1: After synchronous active-low reset, `wr_en` and `hdr_err` are 0 and the decoder waits for the first header copy.
- R2: A header beat carries the start address in bits 14:8 and the word count in bits 7:0, with bit 15 equal to 0. A packet opens only when the next accepted beat is an identical copy.
- R3: Each payload word is formed as {second beat, first beat}, so the low half arrives first. `wr_en` is high for exactly the one cycle after the edge that accepts the high half, and is never high in two consecutive cycles.
- R4: The first word of a packet is written to the start address, and each following word to the previous address plus one.
- R5: With start address 126, every word of the packet is written to address 126.
- R6: No write ever targets address 127. An incrementing packet that passes 126 continues at address 0.
- R7: If the two copies differ, if bit 15 is set, or if the address is 127, `hdr_err` pulses for one cycle, no write occurs, and both copies are discarded. The next two accepted beats are taken as a fresh header pair.
- R8: A legal header pair with a word count of 0 produces no write and no error, and the next accepted beat is taken as a first header copy.
- R9: After the high half of a packet's last word, the next accepted beat is taken as a first header copy, even when it arrives in the very next cycle.
- R10: Cycles with `in_valid` low change nothing. Idle gaps of any length between header copies or between halves leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | 16 | Header copy or payload half-word |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 7 | Target address of the write |
| wr_data | output | 32 | Assembled 32-bit word |
| hdr_err | output | 1 | One-cycle pulse on a rejected header pair |

## Verification
The write strobe for the last word of a packet and the capture of the first header copy of the next packet can fall in the same cycle. This happens when the host keeps `in_valid` high across the packet boundary. The bench provokes it by sending two packets back to back with no idle beat. It judges the result by the full write log: the second packet must land at its own start address with its own data, and no error may be raised. A second overlap is a rejected header pair followed at once by a good one. Here the error pulse and the first header capture coincide, and the bench checks that exactly one error and exactly the expected writes appear.

// File: rtl/pwd_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the packetized write decoder.
// Assumes: nothing beyond a 2-bit state encoding.
package pwd_pkg;
    // Decoder phase: first header copy, second copy, low half, high half.
    typedef enum logic [1:0] {
        ST_HDR1 = 2'd0,
        ST_HDR2 = 2'd1,
        ST_LO   = 2'd2,
        ST_HI   = 2'd3
    } pwd_state_e;
endpackage

// File: rtl/pwd_hdr_check.sv
`timescale 1ns/1ps
// Module: pwd_hdr_check
// Purpose: splits a header beat into address and count, and decides
//          whether a pair of copies may open a packet.
// Assumes: HW == AW + CW + 1; the top bit is reserved and must be 0.
module pwd_hdr_check #(
    parameter int AW = 7,
    parameter int CW = 8,
    parameter int HW = AW + CW + 1
) (
    input  logic [HW-1:0] first_copy,
    input  logic [HW-1:0] second_copy,
    output logic          pair_ok,
    output logic          count_zero,
    output logic [AW-1:0] hdr_addr,
    output logic [CW-1:0] hdr_count
);
    localparam logic [AW-1:0] ILLEGAL = {AW{1'b1}};

    // Field split and legality of the pair.
    always_comb begin
        hdr_addr   = second_copy[AW+CW-1:CW];
        hdr_count  = second_copy[CW-1:0];
        count_zero = (hdr_count == '0);
        pair_ok    = (first_copy == second_copy) && !second_copy[HW-1]
                     && (hdr_addr != ILLEGAL);
    end
endmodule

// File: rtl/pwd_half_join.sv
`timescale 1ns/1ps
// Module: pwd_half_join
// Purpose: holds the low half of a payload word and presents the joined
//          word while the high half is on the input.
// Assumes: take_lo and take_hi are never high together.
module pwd_half_join #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_lo,
    input  logic          take_hi,
    input  logic [HW-1:0] din,
    output logic [2*HW-1:0] word
);
    logic [HW-1:0] lo_q;
    logic          have_lo;

    // Capture the low half and track that one is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            have_lo <= 1'b0;
        end else if (take_lo) begin
            lo_q    <= din;
            have_lo <= 1'b1;
        end else if (take_hi) begin
            have_lo <= 1'b0;
        end
    end

    // Joined word: high half from the live input.
    assign word = {din, lo_q};

    // A high half is consumed only after a low half was stored (R3).
    p_low_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_hi |-> have_lo);
endmodule

// File: rtl/pwd_addr_step.sv
`timescale 1ns/1ps
// Module: pwd_addr_step
// Purpose: holds the current write address, loads the start address and
//          steps it once per word; a sink start address never moves, and
//          the all-ones address is skipped by wrapping to zero.
// Assumes: load and advance are never high together.
module pwd_addr_step #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start,
    input  logic          advance,
    output logic [AW-1:0] cur
);
    localparam logic [AW-1:0] ILLEGAL = {AW{1'b1}};
    localparam logic [AW-1:0] SINK    = ILLEGAL - 1'b1;

    logic          sink_q;
    logic [AW-1:0] inc;

    // Next incrementing address, skipping the illegal one.
    always_comb begin
        inc = cur + {{(AW-1){1'b0}}, 1'b1};
        if (inc == ILLEGAL) inc = '0;
    end

    // Address register and sink mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            sink_q <= 1'b0;
        end else if (load) begin
            cur    <= start;
            sink_q <= (start == SINK);
        end else if (advance && !sink_q) begin
            cur <= inc;
        end
    end

    // The address used for a write is never the illegal one (R6).
    p_addr_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> cur != ILLEGAL);
endmodule

// File: rtl/pwd_write_decoder.sv
`timescale 1ns/1ps
// Module: pwd_write_decoder (top)
// Purpose: parses duplicated headers from a 16-bit valid/data stream,
//          joins payload halves (low first) into words and issues one
//          registered write per word.
// Assumes: the host sends exactly the announced number of words; a
//          rejected header pair drops both copies and restarts header search.
module pwd_write_decoder #(
    parameter int AW = 7,
    parameter int CW = 8,
    parameter int HW = AW + CW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [HW-1:0]   in_data,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [2*HW-1:0] wr_data,
    output logic            hdr_err
);
    import pwd_pkg::*;

    localparam logic [AW-1:0] ILLEGAL = {AW{1'b1}};
    localparam logic [CW-1:0] ONE_LEFT = {{(CW-1){1'b0}}, 1'b1};

    pwd_state_e      state;
    logic [HW-1:0]   hdr1_q;
    logic [CW-1:0]   left_q;
    logic            pair_ok, count_zero;
    logic [AW-1:0]   hdr_addr, cur_addr;
    logic [CW-1:0]   hdr_count;
    logic [2*HW-1:0] joined;
    logic            take_lo, take_hi, open_pkt;

    // Beat classification for the sub-blocks.
    always_comb begin
        take_lo  = in_valid && (state == ST_LO);
        take_hi  = in_valid && (state == ST_HI);
        open_pkt = in_valid && (state == ST_HDR2) && pair_ok && !count_zero;
    end

    pwd_hdr_check #(.AW(AW), .CW(CW), .HW(HW)) u_hdr (
        .first_copy (hdr1_q),
        .second_copy(in_data),
        .pair_ok    (pair_ok),
        .count_zero (count_zero),
        .hdr_addr   (hdr_addr),
        .hdr_count  (hdr_count)
    );

    pwd_half_join #(.HW(HW)) u_join (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_lo(take_lo),
        .take_hi(take_hi),
        .din    (in_data),
        .word   (joined)
    );

    pwd_addr_step #(.AW(AW)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (open_pkt),
        .start  (hdr_addr),
        .advance(take_hi),
        .cur    (cur_addr)
    );

    // Packet state machine, word counter and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HDR1;
            hdr1_q  <= '0;
            left_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            hdr_err <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            hdr_err <= 1'b0;
            if (in_valid) begin
                unique case (state)
                    ST_HDR1: begin
                        hdr1_q <= in_data;
                        state  <= ST_HDR2;
                    end
                    ST_HDR2: begin
                        if (!pair_ok) begin
                            hdr_err <= 1'b1;
                            state   <= ST_HDR1;
                        end else if (count_zero) begin
                            state <= ST_HDR1;
                        end else begin
                            left_q <= hdr_count;
                            state  <= ST_LO;
                        end
                    end
                    ST_LO: state <= ST_HI;
                    ST_HI: begin
                        wr_en   <= 1'b1;
                        wr_addr <= cur_addr;
                        wr_data <= joined;
                        left_q  <= left_q - ONE_LEFT;
                        state   <= (left_q == ONE_LEFT) ? ST_HDR1 : ST_LO;
                    end
                    default: state <= ST_HDR1;
                endcase
            end
        end
    end

    // Write strobe is a single-cycle pulse (R3).
    p_write_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // Error pulse lasts one cycle (R7).
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |=> !hdr_err);
    // A rejected header never coincides with a write (R7).
    p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_err && wr_en));
    // The port never presents a write to the illegal address (R6).
    p_port_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr != ILLEGAL);
endmodule

// File: tb/pwd_write_decoder_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module pwd_write_decoder_bench;
    localparam int AW = 7;
    localparam int CW = 8;
    localparam int HW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [HW-1:0]   in_data = '0;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [2*HW-1:0] wr_data;
    logic            hdr_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int n_wr = 0;
    int n_err = 0;
    logic [AW-1:0]   log_a [0:63];
    logic [2*HW-1:0] log_d [0:63];

    always #2.5 clk = ~clk;

    pwd_write_decoder #(.AW(AW), .CW(CW), .HW(HW)) u_pwd_write_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hdr_err(hdr_err)
    );

    // Write and error log, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (n_wr < 64) begin
                    log_a[n_wr] = wr_addr;
                    log_d[n_wr] = wr_data;
                end
                n_wr++;
            end
            if (hdr_err) n_err++;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic beat(input logic [HW-1:0] d);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_data  = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        n_wr  = 0;
        n_err = 0;
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] seed, input int i);
        return seed + 32'(i) * 32'h0103_0507;
    endfunction

    function automatic logic [HW-1:0] hdr(input int a, input int n);
        return HW'((a << 8) | n);
    endfunction

    task automatic send_pkt(input int a, input int n, input logic [31:0] seed,
                            input int gap);
        logic [31:0] w;
        beat(hdr(a, n));
        idle(gap);
        beat(hdr(a, n));
        idle(gap);
        for (int i = 0; i < n; i++) begin
            w = word_of(seed, i);
            beat(w[15:0]);
            idle(gap);
            beat(w[31:16]);
            idle(gap);
        end
    endtask

    // Compare log entries from index off against a packet's expected writes.
    task automatic expect_pkt(input int off, input int a, input int n,
                              input logic [31:0] seed, input string req);
        int ea = a;
        for (int i = 0; i < n; i++) begin
            check(log_a[off+i] == AW'(ea), req, 64'(log_a[off+i]), 64'(ea));
            check(log_d[off+i] == word_of(seed, i), req,
                  64'(log_d[off+i]), 64'(word_of(seed, i)));
            if (a != 126) begin
                ea = ea + 1;
                if (ea == 127) ea = 0;
            end
        end
    endtask

    task automatic t_reset();
        check(wr_en == 1'b0, "R1 wr_en after reset", 64'(wr_en), 0);
        check(hdr_err == 1'b0, "R1 hdr_err after reset", 64'(hdr_err), 0);
    endtask

    // Low half first and exact strobe timing; incrementing addresses.
    task automatic t_basic();
        logic [31:0] w;
        clear_log();
        beat(hdr(10, 3));
        beat(hdr(10, 3));
        for (int i = 0; i < 3; i++) begin
            w = word_of(32'h1122_3344, i);
            beat(w[15:0]);
            check(wr_en == 1'b0, "R3 no strobe after low half", 64'(wr_en), 0);
            beat(w[31:16]);
            check(wr_en == 1'b1, "R3 strobe after high half", 64'(wr_en), 1);
            check(wr_data == w, "R3 word is {hi,lo}", 64'(wr_data), 64'(w));
            check(wr_addr == AW'(10 + i), "R4 address step",
                  64'(wr_addr), 64'(10 + i));
        end
        idle(3);
        check(n_wr == 3, "R2 write count", 64'(n_wr), 3);
        check(n_err == 0, "R2 no error", 64'(n_err), 0);
    endtask

    task automatic t_sink();
        clear_log();
        send_pkt(126, 4, 32'hCAFE_0001, 0);
        idle(3);
        check(n_wr == 4, "R5 write count", 64'(n_wr), 4);
        expect_pkt(0, 126, 4, 32'hCAFE_0001, "R5 sink address");
    endtask

    task automatic t_wrap();
        clear_log();
        send_pkt(125, 3, 32'h0BAD_F00D, 0);
        idle(3);
        check(n_wr == 3, "R6 write count", 64'(n_wr), 3);
        expect_pkt(0, 125, 3, 32'h0BAD_F00D, "R6 wrap skips 127");
    endtask

    // Three rejected pairs, then a good one directly after the last.
    task automatic t_bad();
        clear_log();
        beat(hdr(10, 2));
        beat(hdr(11, 2));
        check(hdr_err == 1'b1, "R7 mismatch flagged", 64'(hdr_err), 1);
        beat(16'h8A02);
        check(hdr_err == 1'b0, "R7 pulse one cycle", 64'(hdr_err), 0);
        beat(16'h8A02);
        check(hdr_err == 1'b1, "R7 bit15 flagged", 64'(hdr_err), 1);
        beat(hdr(127, 2));
        beat(hdr(127, 2));
        check(hdr_err == 1'b1, "R6 address 127 rejected", 64'(hdr_err), 1);
        send_pkt(32, 1, 32'h5A5A_A5A5, 0);
        idle(3);
        check(n_err == 3, "R7 error count", 64'(n_err), 3);
        check(n_wr == 1, "R7 only good packet writes", 64'(n_wr), 1);
        expect_pkt(0, 32, 1, 32'h5A5A_A5A5, "R7 resync packet");
    endtask

    task automatic t_zero();
        clear_log();
        beat(hdr(5, 0));
        beat(hdr(5, 0));
        send_pkt(48, 1, 32'h7777_0000, 0);
        idle(3);
        check(n_err == 0, "R8 no error", 64'(n_err), 0);
        check(n_wr == 1, "R8 zero count writes nothing", 64'(n_wr), 1);
        expect_pkt(0, 48, 1, 32'h7777_0000, "R8 next header");
    endtask

    task automatic t_b2b();
        clear_log();
        send_pkt(64, 2, 32'h1000_2000, 0);
        send_pkt(80, 1, 32'h3000_4000, 0);
        idle(3);
        check(n_wr == 3, "R9 write count", 64'(n_wr), 3);
        check(n_err == 0, "R9 no error", 64'(n_err), 0);
        expect_pkt(0, 64, 2, 32'h1000_2000, "R9 first packet");
        expect_pkt(2, 80, 1, 32'h3000_4000, "R9 second packet");
    endtask

    task automatic t_stall();
        clear_log();
        send_pkt(96, 2, 32'hDEAD_0042, 3);
        idle(3);
        check(n_wr == 2, "R10 write count", 64'(n_wr), 2);
        check(n_err == 0, "R10 no error", 64'(n_err), 0);
        expect_pkt(0, 96, 2, 32'hDEAD_0042, "R10 stalled packet");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sink();
        t_wrap();
        t_bad();
        t_zero();
        t_b2b();
        t_stall();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule